// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator

This block is a memory-mapped PWM peripheral. It has four independent channels, and each channel drives one output pin. A channel counts on a tick that it picks from a small group of tick inputs. An external prescaler produces these ticks. The output of a channel is high while its counter is below the programmed duty value.

Each channel runs in one of two modes:
- **Edge mode:** the counter rises and then wraps.
- **Symmetric mode:** the counter rises and then falls, so one output period lasts twice as many ticks.

At the end of every period a channel latches a pending flag. The block raises a single interrupt line while any pending flag has its mask bit set. Reading the pending register returns the flags and clears them.

Software uses the bus to program each channel's bank and then to start it. Starting, stopping, unmasking and masking are all write-one actions on shared global registers, so one write can touch any set of channels without a read-modify-write. A duty or period change made while a channel runs is held back until the next period boundary, so the output never shows a truncated pulse.

Top module: `pwm_core`

## Requirements
- R1: After reset, every channel is stopped, every output and the interrupt line are low, and every readable register (status, mask, pending, duty, period, counter) reads 0.
- R2: A write to 0x04 starts channel n for each 1 in data bit n. A write to 0x08 stops channel n for each 1 in bit n. Zero bits leave channels as they are, and bits at or above 4 are ignored. A read of 0x0C returns the running channels in bits 3:0.
- R3: A write to 0x10 sets mask bit n for each 1 in bit n. A write to 0x14 clears mask bit n for each 1 in bit n. A read of 0x18 returns the mask.
- R4: Channel n has a bank at 0x200 + n*0x20. The bank holds mode at +0x0, duty at +0x4, period at +0x8 and a read-only counter at +0xC. In the mode word, bit 0 selects the tick input and bit 8 selects symmetric mode. Accesses to banks of channel 4 and above are ignored and read 0.
- R5: In edge mode, a running channel counts 0 to period-1 on each selected tick and then wraps to 0. Its output is high while the counter is below duty. A period of 0 behaves as a period of 1.
- R6: In symmetric mode the counter runs 0 up to period-1 and then back down to 0, holding for one tick at each turn. One period lasts 2*period ticks, and the output is high for 2*min(duty, period) of them.
- R7: At each period end (the wrap in edge mode, the bottom turn in symmetric mode), the channel sets its bit in the pending register at 0x1C, whatever its mask bit holds.
- R8: A read of 0x1C returns the pending flags and clears them at the same clock edge.
- R9: The interrupt line is high exactly when some channel has both its pending bit and its mask bit set.
- R10: While a channel runs, writes to its duty or period update the readable value at once but reach the counter and output only at the next period end. While a channel is stopped, its counter holds 0 and its output is low.
- R11: A channel's counter advances only on clock edges where its selected tick input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 2 | Count enables from the prescaler, one per source |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears pending flags on 0x1C) |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Combined interrupt |
| pwm_o | output | 4 | Channel outputs |

## Verification
A vector table drives one channel through pairs of period and duty in both modes. The pairs include:
- duty of zero;
- duty equal to the period;
- duty above the period;
- a period of 0 or 1;

Counting high cycles over a fixed window separates correct compare and wrap behaviour from off-by-one counting and from a symmetric mode that fails to double the period. Directed tests step a channel one tick at a time from a second tick source. These tests separate tick selection, the immediate and the deferred visibility of duty and period writes, and masked from unmasked pending flags. They also show that a single read clears the pending flags. Further cases check the write-one semantics, including ignored upper bits, and that the bank of a fifth channel does not alias onto channel 0.

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int NCH   = 4,
  parameter int CW    = 20,
  parameter int NTICK = 2,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTICK-1:0] tick_i,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             irq_o,
  output logic [NCH-1:0]   pwm_o
);
  localparam int TSW  = (NTICK > 1) ? $clog2(NTICK) : 1;
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SYMB = 8;
  localparam int SLOT0 = 16;

  logic [AW-6:0]  slot;
  logic [2:0]     roff;
  logic           glob, bank_ok;
  logic [CHW-1:0] sel_ch;

  assign slot    = bus_addr[AW-1:5];
  assign roff    = bus_addr[4:2];
  assign glob    = (slot == '0);
  assign bank_ok = (int'(slot) >= SLOT0) && (int'(slot) < SLOT0 + NCH);
  assign sel_ch  = slot[CHW-1:0];

  logic g_en, g_dis, g_ier, g_idr, rd_pend;
  assign g_en    = bus_wr && glob && roff == 3'd1;
  assign g_dis   = bus_wr && glob && roff == 3'd2;
  assign g_ier   = bus_wr && glob && roff == 3'd4;
  assign g_idr   = bus_wr && glob && roff == 3'd5;
  assign rd_pend = bus_rd && glob && roff == 3'd7;

  logic [NCH-1:0] run, pend, mask;
  logic [CW-1:0]  duty_v [NCH];
  logic [CW-1:0]  per_v  [NCH];
  logic [CW-1:0]  cnt_v  [NCH];
  logic [31:0]    mode_v [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic           run_q, dn_q, sym_q, pend_q, mask_q;
    logic [TSW-1:0] ts_q;
    logic [CW-1:0]  duty_r, per_r, duty_a, per_a, cnt_q;
    logic           hit, tk, top, pe;

    assign hit = bus_wr && bank_ok && sel_ch == CHW'(i);
    assign tk  = (int'(ts_q) < NTICK) ? tick_i[ts_q] : 1'b0;
    assign top = (per_a == '0) || (cnt_q == per_a - 1'b1);
    assign pe  = run_q && tk && (sym_q ? (dn_q && cnt_q == '0) : top);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run_q <= 1'b0; dn_q <= 1'b0; sym_q <= 1'b0; ts_q <= '0;
        pend_q <= 1'b0; mask_q <= 1'b0;
        duty_r <= '0; per_r <= '0; duty_a <= '0; per_a <= '0; cnt_q <= '0;
      end else begin
        if (hit && roff == 3'd0) begin
          ts_q  <= bus_wdata[TSW-1:0];
          sym_q <= bus_wdata[SYMB];
        end
        if (hit && roff == 3'd1) duty_r <= bus_wdata[CW-1:0];
        if (hit && roff == 3'd2) per_r  <= bus_wdata[CW-1:0];

        if (g_dis && bus_wdata[i])     run_q <= 1'b0;
        else if (g_en && bus_wdata[i]) run_q <= 1'b1;

        if (!run_q || (g_dis && bus_wdata[i])) begin
          cnt_q  <= '0;
          dn_q   <= 1'b0;
          duty_a <= (hit && roff == 3'd1) ? bus_wdata[CW-1:0] : duty_r;
          per_a  <= (hit && roff == 3'd2) ? bus_wdata[CW-1:0] : per_r;
        end else if (tk) begin
          if (!sym_q) begin
            if (top) begin
              cnt_q <= '0; duty_a <= duty_r; per_a <= per_r;
            end else cnt_q <= cnt_q + 1'b1;
          end else if (!dn_q) begin
            if (top) dn_q <= 1'b1;
            else     cnt_q <= cnt_q + 1'b1;
          end else begin
            if (cnt_q == '0) begin
              dn_q <= 1'b0; duty_a <= duty_r; per_a <= per_r;
            end else cnt_q <= cnt_q - 1'b1;
          end
        end

        if (pe)           pend_q <= 1'b1;
        else if (rd_pend) pend_q <= 1'b0;

        if (g_idr && bus_wdata[i])      mask_q <= 1'b0;
        else if (g_ier && bus_wdata[i]) mask_q <= 1'b1;
      end
    end

    assign run[i]    = run_q;
    assign pend[i]   = pend_q;
    assign mask[i]   = mask_q;
    assign pwm_o[i]  = run_q && (cnt_q < duty_a);
    assign duty_v[i] = duty_r;
    assign per_v[i]  = per_r;
    assign cnt_v[i]  = cnt_q;
    always_comb begin
      mode_v[i]            = '0;
      mode_v[i][TSW-1:0]   = ts_q;
      mode_v[i][SYMB]      = sym_q;
    end
  end

  assign irq_o = |(pend & mask);

  always_comb begin
    bus_rdata = '0;
    if (glob) begin
      case (roff)
        3'd3:    bus_rdata[NCH-1:0] = run;
        3'd6:    bus_rdata[NCH-1:0] = mask;
        3'd7:    bus_rdata[NCH-1:0] = pend;
        default: bus_rdata = '0;
      endcase
    end else if (bank_ok) begin
      case (roff)
        3'd0:    bus_rdata = mode_v[sel_ch];
        3'd1:    bus_rdata[CW-1:0] = duty_v[sel_ch];
        3'd2:    bus_rdata[CW-1:0] = per_v[sel_ch];
        3'd3:    bus_rdata[CW-1:0] = cnt_v[sel_ch];
        default: bus_rdata = '0;
      endcase
    end
  end

  logic [NCH*CW-1:0] cnt_flat;
  for (genvar i = 0; i < NCH; i++) begin : g_flat
    assign cnt_flat[i*CW +: CW] = cnt_v[i];
  end
endmodule

module pwm_core_chk #(
  parameter int NCH   = 4,
  parameter int CW    = 20,
  parameter int NTICK = 2,
  parameter int AW    = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NTICK-1:0]  tick_i,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [AW-1:0]     bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NCH-1:0]    pwm_o,
  input logic [NCH-1:0]    run,
  input logic [NCH-1:0]    pend,
  input logic [NCH-1:0]    mask,
  input logic [NCH*CW-1:0] cnt_flat
);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h04)) |=> ((run & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

  assert_unmask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'('h10)) |=> ((mask & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'('h1C) && tick_i == '0) |=> (pend == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_flag_from_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) |-> $past(run[i]));

    assert_stopped_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !run[i] |-> (cnt_flat[i*CW +: CW] == '0 && !pwm_o[i]));
  end
endmodule

bind pwm_core pwm_core_chk #(.NCH(NCH), .CW(CW), .NTICK(NTICK), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pwm_o(pwm_o), .run(run),
  .pend(pend), .mask(mask), .cnt_flat(cnt_flat)
);

// File: tb/pwm_core_tb.sv
module pwm_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        t1 = 1'b0;
  logic [1:0]  tick;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic [3:0]  pwm_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  assign tick = {t1, 1'b1};
  always #2 clk = ~clk;

  pwm_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .pwm_o(pwm_o)
  );

  // mode, period, duty, window, expected high cycles
  localparam int NV = 11;
  localparam int VEC [NV][5] = '{
    '{'h000, 10,  3, 20,  6},
    '{'h000, 10,  0, 20,  0},
    '{'h000, 10, 10, 20, 20},
    '{'h000, 10, 15, 20, 20},
    '{'h000,  1,  1,  2,  2},
    '{'h000,  5,  2, 10,  4},
    '{'h000,  0,  1,  2,  2},
    '{'h100,  4,  1,  8,  2},
    '{'h100,  6,  4, 12,  8},
    '{'h100,  1,  1,  2,  2},
    '{'h100,  3,  5,  6,  6}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    bus_rd = 1'b1; bus_addr = 12'(a);
    #1 d = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse1();
    t1 = 1'b1;
    @(negedge clk);
    t1 = 1'b0;
  endtask

  initial begin
    int v, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd('h0C, v); chk("R1 status", v, 0);
    rd('h18, v); chk("R1 mask", v, 0);
    rd('h1C, v); chk("R1 pending", v, 0);
    rd('h204, v); chk("R1 duty", v, 0);
    rd('h208, v); chk("R1 period", v, 0);
    rd('h20C, v); chk("R1 counter", v, 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 pwm", int'(pwm_o), 0);

    // R5 / R6 vector table on channel 0, tick source 0 always high
    for (int k = 0; k < NV; k++) begin
      wr('h08, 1);
      wr('h200, VEC[k][0]);
      wr('h204, VEC[k][2]);
      wr('h208, VEC[k][1]);
      wr('h04, 1);
      hi = 0;
      for (int c = 0; c < VEC[k][3]; c++) begin
        if (pwm_o[0]) hi++;
        @(negedge clk);
      end
      chk((VEC[k][0] != 0) ? "R6 symmetric high count" : "R5 edge high count", hi, VEC[k][4]);
    end

    // R2 write-one start/stop
    wr('h08, 'hF);
    wr('h04, 'h5); rd('h0C, v); chk("R2 start 0101", v, 5);
    wr('h04, 'h2); rd('h0C, v); chk("R2 start adds 0010", v, 7);
    wr('h08, 'h4); rd('h0C, v); chk("R2 stop 0100", v, 3);
    wr('h04, 'hF0); rd('h0C, v); chk("R2 upper bits ignored", v, 3);
    wr('h08, 'hF); rd('h0C, v); chk("R2 stop all", v, 0);
    rd('h1C, v);
    rd('h1C, v); chk("R8 pending cleared when stopped", v, 0);

    // R3 mask set/clear
    wr('h10, 'h9); rd('h18, v); chk("R3 set mask", v, 9);
    wr('h14, 'h1); rd('h18, v); chk("R3 clear bit0", v, 8);
    wr('h14, 'h8); rd('h18, v); chk("R3 clear bit3", v, 0);

    // R4 fifth bank ignored, no alias on channel 0
    wr('h204, 7);
    wr('h284, 'h55);
    rd('h284, v); chk("R4 bank 4 reads 0", v, 0);
    rd('h204, v); chk("R4 ch0 duty unaffected", v, 7);
    wr('h220, 'h101); rd('h220, v); chk("R4 mode readback", v, 'h101);

    // R11 / R5 / R7 / R9 / R8 on channel 1 with tick source 1
    wr('h220, 1);
    wr('h228, 2);
    wr('h224, 1);
    wr('h04, 2);
    repeat (3) @(negedge clk);
    rd('h22C, v); chk("R11 no advance on unselected tick", v, 0);
    chk("R5 output high at count 0", int'(pwm_o[1]), 1);
    pulse1();
    rd('h22C, v); chk("R11 advance on selected tick", v, 1);
    chk("R5 output low at count 1", int'(pwm_o[1]), 0);
    rd('h1C, v); chk("R7 no flag mid-period", v, 0);
    pulse1();
    chk("R9 masked flag keeps irq low", int'(irq_o), 0);
    wr('h10, 2);
    chk("R9 irq high once unmasked", int'(irq_o), 1);
    rd('h1C, v); chk("R7 flag at wrap", v, 2);
    chk("R8 irq low after acknowledge", int'(irq_o), 0);
    rd('h1C, v); chk("R8 second read empty", v, 0);

    // R10 deferred period and duty
    wr('h228, 4);
    pulse1(); pulse1(); pulse1(); pulse1();
    rd('h22C, v); chk("R10 new period after boundary", v, 2);
    wr('h224, 3);
    chk("R10 duty not applied mid-period", int'(pwm_o[1]), 0);
    rd('h224, v); chk("R10 duty readback immediate", v, 3);
    pulse1(); pulse1(); pulse1();
    chk("R10 duty applied next period", int'(pwm_o[1]), 1);

    wr('h08, 2);
    chk("R10 stopped output low", int'(pwm_o[1]), 0);
    rd('h22C, v); chk("R10 stopped counter zero", v, 0);
    rd('h0C, v); chk("R2 all stopped", v, 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule